// File: doc/BRIEF.md
# Reset Cause and Configuration Controller

This block sits between the reset sources and the CPU of a small 8-bit microcontroller. It watches three reset sources: the power-on / external-pin reset (the synchronous active-low `rst_n`), a clock-monitor failure flag and a watchdog timeout flag. It decides which source caused each reset and records it. It then hands the CPU the matching 16-bit vector address. That address depends on both the cause and the operating mode (normal, or special test/bootstrap), and the mode is sampled when the reset request is taken.

After a reset request goes away, the CPU is released through a fixed three-cycle vector fetch. The high-byte address comes on the first cycle, the low-byte address on the second, and a done strobe on the third. During all three cycles a pulse forces the CPU's X and I interrupt masks and its stop-inhibit bit set. The block also holds an 8-bit configuration register with two bits:

- a watchdog-disable bit, whose reset value depends on the mode and which can be written only once in normal mode;
- an on-chip ROM enable bit.

The block drives a watchdog-enable output that is the inverse of the watchdog-disable bit.

Top module: `rstctl_top`

## Requirements
- R1: The configuration read value has bit 2 = watchdog disable and bit 1 = ROM enable. Bits 7..3 and bit 0 always read 0.
- R2: Any reset request loads watchdog disable = 0 in normal mode and = 1 in special mode, and loads ROM enable = 1. The mode used is `mode_special_i` as sampled at that edge.
- R3: In normal mode, the first configuration write after a reset sets a lock. While the lock is set, later writes leave bit 2 unchanged but still update bit 1. Only a reset request clears the lock.
- R4: In special mode, every configuration write updates bit 2.
- R5: The vector low-byte offset is selected by the reset cause: pin/power-on gives $FE, clock-monitor failure gives $FC, watchdog timeout gives $FA. The vector page is $FF in normal mode and $BF in special mode, so the fetch addresses are {page, offset} and then {page, offset|1}.
- R6: When several sources are active in the same cycle, the priority is pin/power-on, then clock-monitor failure, then watchdog timeout.
- R7: `wdt_en_o` is the inverse of configuration bit 2. A watchdog timeout causes a reset only while `wdt_en_o` is 1; otherwise it has no effect.
- R8: `cpu_rst_o` is 1 during every cycle after a clock edge that saw a reset request, and for one further cycle once the request is gone. After that come one cycle with `vec_fetch_o`=1 and the even address, one cycle with `vec_fetch_o`=1 and the odd address, and one cycle with `vec_done_o`=1. A new request at any point restarts the sequence.
- R9: `mask_set_o` is 1 exactly during the two fetch cycles and the done cycle.
- R10: Configuration writes made while `cpu_rst_o` is 1 are ignored.
- R11: The mode is latched only on a reset request. Changing `mode_special_i` afterwards changes neither the vector page nor the write rule for bit 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Power-on / pin reset, synchronous, active low |
| mode_special_i | input | 1 | 1 = special (test/bootstrap) mode, 0 = normal mode |
| clkmon_fail_i | input | 1 | Clock-monitor failure flag |
| wdt_timeout_i | input | 1 | Watchdog timeout flag |
| cfg_we_i | input | 1 | Configuration register write strobe |
| cfg_wdata_i | input | 8 | Configuration write data |
| cfg_rdata_o | output | 8 | Configuration register read value |
| wdt_en_o | output | 1 | Watchdog enable (inverse of disable bit) |
| cpu_rst_o | output | 1 | Holds the CPU in reset |
| vec_fetch_o | output | 1 | Vector fetch address is valid |
| vec_addr_o | output | 16 | Vector fetch address |
| vec_done_o | output | 1 | Vector fetch complete strobe |
| mask_set_o | output | 1 | Forces the X, I and S bits of the CPU set |

## Verification
The assertions assume that the sources of a reset request (`rst_n`, `clkmon_fail_i` and `wdt_timeout_i` gated by `wdt_en_o`) come only from the block's inputs. The sequence checks therefore hold only in cycles where none of them is active, and each check is guarded by that condition instead of assuming requests never arrive mid-sequence. They also assume all inputs change only between clock edges. The stimulus meets this by driving every input on the falling edge. The stimulus deliberately toggles the mode strap and issues writes inside the reset window and during the fetch cycles, so that the latched mode and the write gating are both exercised.

// File: rtl/rstctl_pkg.sv
// Package: shared types and constants for the reset cause and configuration
// controller. Assumes an 8-bit vector offset within a page.
package rstctl_pkg;

    // Recorded reset cause, ordered by priority (first = highest).
    typedef enum logic [1:0] {
        CAUSE_EXT = 2'd0,
        CAUSE_CLK = 2'd1,
        CAUSE_WDT = 2'd2
    } cause_e;

    // Release sequence phase.
    typedef enum logic [2:0] {
        PH_HOLD = 3'd0,
        PH_HI   = 3'd1,
        PH_LO   = 3'd2,
        PH_DONE = 3'd3,
        PH_RUN  = 3'd4
    } phase_e;

    localparam int OFS_W = 8;

    // Even vector offset for a given cause.
    function automatic logic [OFS_W-1:0] cause_offset(cause_e c);
        case (c)
            CAUSE_EXT: return 8'hFE;
            CAUSE_CLK: return 8'hFC;
            default:   return 8'hFA;
        endcase
    endfunction

endpackage

// File: rtl/rstctl_cause.sv
// Module: rstctl_cause
// Merges the reset sources into one request and records the winning cause
// and the operating mode at each request.
// Assumes: all inputs synchronous to clk; wdt_en_i comes from a register.
module rstctl_cause
    import rstctl_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   mode_special_i,
    input  logic   clkmon_fail_i,
    input  logic   wdt_timeout_i,
    input  logic   wdt_en_i,
    output logic   req_o,
    output cause_e cause_o,
    output logic   special_o
);

    cause_e cause_nxt;
    logic   wdt_hit;

    // Gate the watchdog source and resolve priority among active sources.
    always_comb begin
        wdt_hit = wdt_timeout_i & wdt_en_i;
        req_o   = !rst_n || clkmon_fail_i || wdt_hit;
        if (clkmon_fail_i) begin
            cause_nxt = CAUSE_CLK;
        end else begin
            cause_nxt = CAUSE_WDT;
        end
    end

    // Record cause and latch mode on every reset request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cause_o   <= CAUSE_EXT;
            special_o <= mode_special_i;
        end else if (req_o) begin
            cause_o   <= cause_nxt;
            special_o <= mode_special_i;
        end
    end

endmodule

// File: rtl/rstctl_cfg.sv
// Module: rstctl_cfg
// Configuration register holding the watchdog-disable and ROM-enable bits.
// The disable bit is write-once in normal mode and free in special mode.
// Assumes: req_i covers the pin reset; hold_i is high while the CPU is in reset.
module rstctl_cfg #(
    parameter int DATA_W    = 8,
    parameter int DIS_BIT   = 2,
    parameter int ROM_BIT   = 1,
    parameter bit ROM_RESET = 1'b1
) (
    input  logic              clk,
    input  logic              req_i,
    input  logic              mode_i,
    input  logic              special_q_i,
    input  logic              hold_i,
    input  logic              we_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              wdt_en_o
);

    logic dis_q;
    logic rom_q;
    logic lock_q;
    logic wr_ok;
    logic dis_wr_ok;

    // Decide whether a write is taken and whether it may touch the disable bit.
    always_comb begin
        wr_ok     = we_i && !hold_i;
        dis_wr_ok = wr_ok && (special_q_i || !lock_q);
    end

    // Register update: reset values on a request, otherwise gated writes.
    always_ff @(posedge clk) begin
        if (req_i) begin
            dis_q  <= mode_i;
            rom_q  <= ROM_RESET;
            lock_q <= 1'b0;
        end else begin
            if (dis_wr_ok) begin
                dis_q <= wdata_i[DIS_BIT];
            end
            if (wr_ok) begin
                rom_q <= wdata_i[ROM_BIT];
            end
            if (wr_ok && !special_q_i) begin
                lock_q <= 1'b1;
            end
        end
    end

    // Build the read value; unimplemented bits read zero.
    always_comb begin
        rdata_o          = '0;
        rdata_o[DIS_BIT] = dis_q;
        rdata_o[ROM_BIT] = rom_q;
        wdt_en_o         = !dis_q;
    end

endmodule

// File: rtl/rstctl_seq.sv
// Module: rstctl_seq
// Release sequencer: holds the CPU in reset, then presents the even and odd
// vector addresses and a done strobe, forcing the CPU mask bits meanwhile.
// Assumes: cause_i and special_i are stable from the cycle after a request.
module rstctl_seq
    import rstctl_pkg::*;
#(
    parameter int          ADDR_W    = 16,
    parameter logic [7:0]  NORM_PAGE = 8'hFF,
    parameter logic [7:0]  SPEC_PAGE = 8'hBF
) (
    input  logic              clk,
    input  logic              req_i,
    input  cause_e            cause_i,
    input  logic              special_i,
    output logic              cpu_rst_o,
    output logic              fetch_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              done_o,
    output logic              mask_o
);

    localparam int PAGE_W = ADDR_W - OFS_W;

    phase_e            phase_q;
    logic [PAGE_W-1:0] page;
    logic [OFS_W-1:0]  ofs;

    // Advance the release phase; any request restarts from hold.
    always_ff @(posedge clk) begin
        if (req_i) begin
            phase_q <= PH_HOLD;
        end else begin
            case (phase_q)
                PH_HOLD: phase_q <= PH_HI;
                PH_HI:   phase_q <= PH_LO;
                PH_LO:   phase_q <= PH_DONE;
                default: phase_q <= PH_RUN;
            endcase
        end
    end

    // Form the vector address from mode page and cause offset.
    always_comb begin
        page    = special_i ? PAGE_W'(SPEC_PAGE) : PAGE_W'(NORM_PAGE);
        ofs     = cause_offset(cause_i);
        ofs[0]  = (phase_q == PH_LO);
        addr_o  = {page, ofs};
    end

    // Decode phase into CPU-facing strobes.
    always_comb begin
        cpu_rst_o = (phase_q == PH_HOLD);
        fetch_o   = (phase_q == PH_HI) || (phase_q == PH_LO);
        done_o    = (phase_q == PH_DONE);
        mask_o    = fetch_o || done_o;
    end

endmodule

// File: rtl/rstctl_top.sv
// Module: rstctl_top
// Reset cause and configuration controller top: ties cause capture,
// configuration register and release sequencer together.
// Assumes: rst_n is a synchronous active-low power-on / pin reset.
module rstctl_top
    import rstctl_pkg::*;
#(
    parameter int         ADDR_W    = 16,
    parameter int         DATA_W    = 8,
    parameter logic [7:0] NORM_PAGE = 8'hFF,
    parameter logic [7:0] SPEC_PAGE = 8'hBF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_special_i,
    input  logic              clkmon_fail_i,
    input  logic              wdt_timeout_i,
    input  logic              cfg_we_i,
    input  logic [DATA_W-1:0] cfg_wdata_i,
    output logic [DATA_W-1:0] cfg_rdata_o,
    output logic              wdt_en_o,
    output logic              cpu_rst_o,
    output logic              vec_fetch_o,
    output logic [ADDR_W-1:0] vec_addr_o,
    output logic              vec_done_o,
    output logic              mask_set_o
);

    logic   req;
    cause_e cause;
    logic   special_q;

    rstctl_cause u_cause (
        .clk            (clk),
        .rst_n          (rst_n),
        .mode_special_i (mode_special_i),
        .clkmon_fail_i  (clkmon_fail_i),
        .wdt_timeout_i  (wdt_timeout_i),
        .wdt_en_i       (wdt_en_o),
        .req_o          (req),
        .cause_o        (cause),
        .special_o      (special_q)
    );

    rstctl_cfg #(
        .DATA_W (DATA_W)
    ) u_cfg (
        .clk         (clk),
        .req_i       (req),
        .mode_i      (mode_special_i),
        .special_q_i (special_q),
        .hold_i      (cpu_rst_o),
        .we_i        (cfg_we_i),
        .wdata_i     (cfg_wdata_i),
        .rdata_o     (cfg_rdata_o),
        .wdt_en_o    (wdt_en_o)
    );

    rstctl_seq #(
        .ADDR_W    (ADDR_W),
        .NORM_PAGE (NORM_PAGE),
        .SPEC_PAGE (SPEC_PAGE)
    ) u_seq (
        .clk       (clk),
        .req_i     (req),
        .cause_i   (cause),
        .special_i (special_q),
        .cpu_rst_o (cpu_rst_o),
        .fetch_o   (vec_fetch_o),
        .addr_o    (vec_addr_o),
        .done_o    (vec_done_o),
        .mask_o    (mask_set_o)
    );

endmodule

// File: rtl/rstctl_chk.sv
// Module: rstctl_chk
// Property checker bound to rstctl_top; observes ports only.
module rstctl_chk #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clkmon_fail_i,
    input logic              wdt_timeout_i,
    input logic              cfg_we_i,
    input logic [DATA_W-1:0] cfg_rdata_o,
    input logic              wdt_en_o,
    input logic              cpu_rst_o,
    input logic              vec_fetch_o,
    input logic [ADDR_W-1:0] vec_addr_o,
    input logic              vec_done_o,
    input logic              mask_set_o
);

    logic quiet;
    logic unused_we;
    assign quiet     = !clkmon_fail_i && !(wdt_timeout_i && wdt_en_o);
    assign unused_we = cfg_we_i;

    // R1
    unimpl_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rdata_o[DATA_W-1:3] == '0 && !cfg_rdata_o[0]);

    // R7
    wdt_en_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_en_o == !cfg_rdata_o[2]);

    // R8
    hold_to_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rst_o && quiet) |=> (vec_fetch_o && !vec_addr_o[0]));

    // R8
    hi_to_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_fetch_o && !vec_addr_o[0] && quiet)
        |=> (vec_fetch_o && vec_addr_o[0] && $stable(vec_addr_o[ADDR_W-1:1])));

    // R8
    lo_to_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_fetch_o && vec_addr_o[0] && quiet) |=> vec_done_o);

    // R8
    request_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !quiet |=> cpu_rst_o);

    // R9
    mask_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mask_set_o == (vec_fetch_o || vec_done_o));

    // R10
    hold_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rst_o && quiet) |=> $stable(cfg_rdata_o));

endmodule

bind rstctl_top rstctl_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .clkmon_fail_i (clkmon_fail_i),
    .wdt_timeout_i (wdt_timeout_i),
    .cfg_we_i      (cfg_we_i),
    .cfg_rdata_o   (cfg_rdata_o),
    .wdt_en_o      (wdt_en_o),
    .cpu_rst_o     (cpu_rst_o),
    .vec_fetch_o   (vec_fetch_o),
    .vec_addr_o    (vec_addr_o),
    .vec_done_o    (vec_done_o),
    .mask_set_o    (mask_set_o)
);

// File: tb/rstctl_top_tb.sv
// Bench: behavioural reference model compared against the DUT every cycle.
module rstctl_top_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode = 1'b0;
    logic        cm = 1'b0;
    logic        wto = 1'b0;
    logic        we = 1'b0;
    logic [7:0]  wd = 8'h00;
    logic [7:0]  rdata;
    logic        wdt_en, cpu_rst, fetch, done, mask;
    logic [15:0] addr;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    rstctl_top u_dut (
        .clk (clk), .rst_n (rst_n), .mode_special_i (mode),
        .clkmon_fail_i (cm), .wdt_timeout_i (wto),
        .cfg_we_i (we), .cfg_wdata_i (wd), .cfg_rdata_o (rdata),
        .wdt_en_o (wdt_en), .cpu_rst_o (cpu_rst), .vec_fetch_o (fetch),
        .vec_addr_o (addr), .vec_done_o (done), .mask_set_o (mask)
    );

    // Reference model state: phase counts cycles since the last request.
    int        m_phase = 0;
    bit        m_spec = 0, m_dis = 0, m_rom = 1, m_lock = 0, started = 0;
    bit [7:0]  m_ofs = 8'hFE;

    always @(posedge clk) begin
        bit req;
        req = !rst_n || cm || (wto && !m_dis);
        if (req) begin
            // R6 priority: pin, then clock monitor, then watchdog (R5 offsets)
            m_ofs   = !rst_n ? 8'hFE : (cm ? 8'hFC : 8'hFA);
            m_phase = 0;
            m_spec  = mode;
            m_dis   = mode;
            m_rom   = 1;
            m_lock  = 0;
        end else begin
            if (we && m_phase != 0) begin
                m_rom = wd[1];
                if (m_spec || !m_lock) m_dis = wd[2];
                if (!m_spec) m_lock = 1;
            end
            if (m_phase < 4) m_phase++;
        end
        started = 1;
    end

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s at %0t: actual=%0h expected=%0h", tag, $time, act, exp);
        end
    endtask

    // Compare every output away from the rising edge.
    always @(negedge clk) begin
        if (started) begin
            chk("R1/R2/R3/R4/R10 cfg_rdata", rdata, {5'b0, m_dis, m_rom, 1'b0});
            chk("R7 wdt_en", wdt_en, !m_dis);
            chk("R8 cpu_rst", cpu_rst, m_phase == 0);
            chk("R8 vec_fetch", fetch, m_phase == 1 || m_phase == 2);
            chk("R8 vec_done", done, m_phase == 3);
            chk("R9 mask_set", mask, m_phase >= 1 && m_phase <= 3);
            if (m_phase == 1 || m_phase == 2)
                chk("R5/R6/R11 vec_addr", addr,
                    {m_spec ? 8'hBF : 8'hFF, m_ofs | 8'(m_phase == 2)});
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] d);
        @(negedge clk); we = 1; wd = d;
        @(negedge clk); we = 0;
    endtask

    initial begin
        // R2 reset state, normal mode, pin cause (R5)
        cyc(3); rst_n = 1; cyc(6);
        // R3 first write disables watchdog and locks; later writes keep bit 2
        wr(8'hFF); cyc(1);
        wr(8'h00); wr(8'h02); cyc(1);
        // R7 timeout ignored while watchdog disabled
        @(negedge clk); wto = 1; cyc(3); wto = 0; cyc(2);
        // R11 mode strap change without reset has no effect on lock
        mode = 1; wr(8'h00); mode = 0; cyc(1);
        // R5 clock-monitor cause, lock cleared, watchdog re-enabled
        @(negedge clk); cm = 1; @(negedge clk); cm = 0; cyc(6);
        // R7 watchdog timeout now effective
        @(negedge clk); wto = 1; @(negedge clk); wto = 0; cyc(6);
        // R6 clock monitor beats watchdog
        @(negedge clk); cm = 1; wto = 1; @(negedge clk); cm = 0; wto = 0; cyc(6);
        // R6 pin beats clock monitor
        @(negedge clk); rst_n = 0; cm = 1; @(negedge clk); rst_n = 1; cm = 0; cyc(6);
        // R10 writes during hold ignored, then mid-sequence restart (R8)
        @(negedge clk); cm = 1; we = 1; wd = 8'h04;
        cyc(2); cm = 0; cyc(1); we = 0; cyc(1);
        wto = 1; @(negedge clk); wto = 0; cyc(6);
        // R4 special mode: disable bit freely writable, pages $BF
        mode = 1; @(negedge clk); rst_n = 0; @(negedge clk); rst_n = 1; cyc(6);
        wr(8'h00); wr(8'h04); wr(8'h00); wr(8'h06);
        wr(8'h00);
        // R11 strap back to normal: special rules and page still apply
        mode = 0; wr(8'h04); wr(8'h00); cyc(1);
        @(negedge clk); wto = 1; @(negedge clk); wto = 0; cyc(6);
        mode = 1;
        @(negedge clk); cm = 1; @(negedge clk); cm = 0; cyc(6);
        cyc(4);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule